// File: doc/BRIEF.md
# Converter Board Register File

This block is the small set of memory-mapped registers that a multi-channel pulse converter board presents to its management bus. The bus is a plain 32-bit, byte-addressed port with separate read and write strobes and a one-cycle acknowledge. The block answers every access itself. It holds a fixed identification word and a status word. The status word gathers a build version, switch positions, rear-module presence lines and a sticky flag raised by an external communication watchdog. It also holds a control word that can request a logic reset, but only through a two-write unlock sequence.

The per-channel pulse counters are kept by the channel logic, not here. For those words this block decodes the address. On a write it raises one load strobe per channel together with the written data. On a read it returns the value the channel presents. A word address is the byte address divided by four. Software that numbers registers from one uses the word address plus one.

Top module: `brd_regfile`

## Requirements
- R1: Every cycle with `bus_we` or `bus_re` high is acknowledged by `bus_ack` high in the following cycle. `bus_rdata` carries the read value in that ack cycle and is zero in every other cycle.
- R2: A read at byte address 0x00 returns the `BOARD_ID` parameter. Writes to it change nothing.
- R3: A read at 0x04 returns the status word. Bits 7:0 hold `GW_VERSION` (upper nibble major, lower nibble minor). Bits 15:8 hold `sw_off` (1 = switch off). Bits 21:16 hold `rear_idle` (1 = line inactive). Bit 22 holds the timeout flag. Bits 31:23 read 0. Writes to bits other than 22 have no effect.
- R4: The timeout flag is 0 after reset. A one-cycle `wdog_expired` pulse sets it, and it then stays set until cleared.
- R5: A write to 0x04 with bit 22 = 1 clears the timeout flag, and a write with bit 22 = 0 leaves it unchanged. If a clear and a set pulse fall in the same cycle, the flag ends up set.
- R6: The control word at 0x08 has bit 0 = unlock and bit 1 = reset. It reads back as {30'b0, reset, unlock} and is 0 after reset.
- R7: A control write with bit 1 = 1 drives `remote_rst` high for exactly one cycle, in the ack cycle, only if unlock was already 1 before that write. Without a prior unlock, the write produces no pulse.
- R8: A control write that fires the reset clears unlock. Any other control write loads unlock from its bit 0. Reads do not change unlock.
- R9: A write to channel word k (byte address 0x0C + 4*k, k = 0..5) raises `cnt_load[k]` alone for one cycle in the ack cycle, with `cnt_wdata` equal to the written data.
- R10: A read of channel word k returns `cnt_rdata[32*k +: 32]` as sampled in the strobe cycle.
- R11: An access to an address not listed above, or with the low two address bits non-zero, is acknowledged, reads 0, raises no load strobe and no reset, and changes no register.
- R12: While `rst_n` is low, `bus_ack`, `bus_rdata`, `cnt_load` and `remote_rst` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_ack | output | 1 | Acknowledge, one cycle after a strobe |
| bus_rdata | output | 32 | Read data, valid with ack |
| sw_off | input | 8 | Switch positions, 1 = off |
| rear_idle | input | 6 | Rear-module detect lines, 1 = inactive |
| wdog_expired | input | 1 | Watchdog timeout pulse |
| remote_rst | output | 1 | One-cycle reset request |
| cnt_load | output | NUM_CH | Per-channel counter load strobes |
| cnt_wdata | output | 32 | Data for counter load |
| cnt_rdata | input | 32*NUM_CH | Current counter values from channels |

## Verification
The status word is read with an asymmetric switch and rear-line pattern, so a swapped or shifted field shows up. The timeout flag is driven in three ways: a set followed by an idle read, a clear write with bit 22 low and then high, and a set coinciding with a clear. Together these separate sticky, clear and priority errors. The reset guard is tried with no unlock, with unlock then reset, with an intervening read, and with an unlock cancelled by a zero write. Each counter channel gets a distinct read pattern and a write, so mis-decoded channels are told apart, and unmapped and misaligned addresses are probed for silence.

// File: rtl/brd_regfile_pkg.sv
package brd_regfile_pkg;
  // Word indices (byte address / 4) of the mapped registers.
  localparam int IDX_ID   = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_CTRL = 2;
  localparam int IDX_CNT0 = 3;

  // Status word field positions.
  localparam int ST_VER_LSB  = 0;
  localparam int ST_SW_LSB   = 8;
  localparam int ST_REAR_LSB = 16;
  localparam int ST_TMO_BIT  = 22;

  // Control word bits.
  localparam int CT_UNLOCK_BIT = 0;
  localparam int CT_RESET_BIT  = 1;

  typedef struct packed {
    logic id;
    logic stat;
    logic ctrl;
  } fixed_sel_t;
endpackage

// File: rtl/brd_addr_decode.sv
module brd_addr_decode
  import brd_regfile_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_CH = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output fixed_sel_t        fsel,
  output logic [NUM_CH-1:0] csel,
  output logic              hit
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic              aligned;

  assign widx    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  assign fsel.id   = aligned && (widx == WIDX_W'(IDX_ID));
  assign fsel.stat = aligned && (widx == WIDX_W'(IDX_STAT));
  assign fsel.ctrl = aligned && (widx == WIDX_W'(IDX_CTRL));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign csel[g] = aligned && (widx == WIDX_W'(IDX_CNT0 + g));
  end

  assign hit = fsel.id | fsel.stat | fsel.ctrl | (|csel);

  always_comb begin
    assert_sel_onehot_R11: assert ($onehot0({fsel.id, fsel.stat, fsel.ctrl, csel}));
  end
endmodule

// File: rtl/brd_status_reg.sv
module brd_status_reg
  import brd_regfile_pkg::*;
#(
  parameter logic [7:0] GW_VERSION = 8'h11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  sw_off,
  input  logic [5:0]  rear_idle,
  input  logic        set_pulse,
  input  logic        clr_req,
  output logic [31:0] stat_word
);
  logic tmo_q;
  logic tmo_d;
  logic tmo_en;

  // Set has priority over a clear in the same cycle.
  always_comb begin
    tmo_en = set_pulse | clr_req;
    tmo_d  = set_pulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmo_q <= 1'b0;
    else if (tmo_en) tmo_q <= tmo_d;
  end

  always_comb begin
    stat_word = '0;
    stat_word[ST_VER_LSB  +: 8] = GW_VERSION;
    stat_word[ST_SW_LSB   +: 8] = sw_off;
    stat_word[ST_REAR_LSB +: 6] = rear_idle;
    stat_word[ST_TMO_BIT]       = tmo_q;
  end

  assert_tmo_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tmo_q) |-> $past(clr_req) && !$past(set_pulse));
  assert_tmo_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |=> tmo_q);
endmodule

// File: rtl/brd_ctrl_reg.sv
module brd_ctrl_reg
  import brd_regfile_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_bits,
  output logic [1:0] ctrl_word,
  output logic       rst_req
);
  logic unlock_q, unlock_d;
  logic fire_q, fire_d;
  logic fire;

  always_comb begin
    fire     = wr_en && wr_bits[CT_RESET_BIT] && unlock_q;
    fire_d   = fire;
    unlock_d = unlock_q;
    if (wr_en) unlock_d = fire ? 1'b0 : wr_bits[CT_UNLOCK_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock_q <= 1'b0;
      fire_q   <= 1'b0;
    end else begin
      unlock_q <= unlock_d;
      fire_q   <= fire_d;
    end
  end

  assign rst_req = fire_q;
  assign ctrl_word[CT_UNLOCK_BIT] = unlock_q;
  assign ctrl_word[CT_RESET_BIT]  = fire_q;

  assert_reset_needs_unlock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> $past(unlock_q) && $past(wr_en));
  assert_reset_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |=> !fire_q);
  assert_fire_clears_unlock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> !unlock_q);
endmodule

// File: rtl/brd_regfile.sv
module brd_regfile
  import brd_regfile_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          NUM_CH     = 6,
  parameter logic [31:0] BOARD_ID   = 32'h54_42_4C_31,
  parameter logic [7:0]  GW_VERSION = 8'h11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_we,
  input  logic                 bus_re,
  output logic                 bus_ack,
  output logic [31:0]          bus_rdata,
  input  logic [7:0]           sw_off,
  input  logic [5:0]           rear_idle,
  input  logic                 wdog_expired,
  output logic                 remote_rst,
  output logic [NUM_CH-1:0]    cnt_load,
  output logic [31:0]          cnt_wdata,
  input  logic [32*NUM_CH-1:0] cnt_rdata
);
  fixed_sel_t        fsel;
  logic [NUM_CH-1:0] csel;
  logic              hit;
  logic [31:0]       stat_word;
  logic [1:0]        ctrl_word;

  logic              ack_q, ack_d;
  logic [31:0]       rdata_q, rdata_d, rd_mux;
  logic [NUM_CH-1:0] load_q, load_d;
  logic [31:0]       wdat_q;
  logic              wdat_en;

  brd_addr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
    .addr (bus_addr),
    .fsel (fsel),
    .csel (csel),
    .hit  (hit)
  );

  brd_status_reg #(.GW_VERSION(GW_VERSION)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_off    (sw_off),
    .rear_idle (rear_idle),
    .set_pulse (wdog_expired),
    .clr_req   (bus_we && fsel.stat && bus_wdata[ST_TMO_BIT]),
    .stat_word (stat_word)
  );

  brd_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_we && fsel.ctrl),
    .wr_bits   (bus_wdata[1:0]),
    .ctrl_word (ctrl_word),
    .rst_req   (remote_rst)
  );

  always_comb begin
    rd_mux = '0;
    if (fsel.id)   rd_mux = BOARD_ID;
    if (fsel.stat) rd_mux = stat_word;
    if (fsel.ctrl) rd_mux = {30'b0, ctrl_word};
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (csel[ch]) rd_mux = cnt_rdata[32*ch +: 32];
    end
  end

  always_comb begin
    ack_d   = bus_we | bus_re;
    rdata_d = bus_re ? rd_mux : '0;
    load_d  = bus_we ? csel : '0;
    wdat_en = bus_we && (|csel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
      load_q  <= '0;
    end else begin
      ack_q   <= ack_d;
      rdata_q <= rdata_d;
      load_q  <= load_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wdat_q <= '0;
    else if (wdat_en) wdat_q <= bus_wdata;
  end

  assign bus_ack   = ack_q;
  assign bus_rdata = rdata_q;
  assign cnt_load  = load_q;
  assign cnt_wdata = wdat_q;

  assert_ack_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we || bus_re) |=> bus_ack);
  assert_no_ack_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we || bus_re) |=> !bus_ack && (bus_rdata == '0));
  assert_load_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cnt_load));
  assert_load_from_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|cnt_load) |-> $past(bus_we) && bus_ack);
  assert_unmapped_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !hit) |=> (bus_rdata == '0) && (cnt_load == '0));
  assert_unmapped_no_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !remote_rst);
endmodule

// File: tb/brd_regfile_tb_top.sv
`timescale 1ns/1ps
module brd_regfile_tb_top;
  localparam int          NCH  = 6;
  localparam logic [31:0] BID  = 32'h54_42_4C_31;
  localparam logic [7:0]  GVER = 8'h11;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [7:0]        bus_addr;
  logic [31:0]       bus_wdata;
  logic              bus_we, bus_re;
  logic              bus_ack;
  logic [31:0]       bus_rdata;
  logic [7:0]        sw_off;
  logic [5:0]        rear_idle;
  logic              wdog_expired;
  logic              remote_rst;
  logic [NCH-1:0]    cnt_load;
  logic [31:0]       cnt_wdata;
  logic [32*NCH-1:0] cnt_rdata;

  int total = 0;
  int bad   = 0;

  logic              s_ack, s_rst;
  logic [NCH-1:0]    s_load;
  logic [31:0]       s_data;

  always #2.5 clk = ~clk;

  brd_regfile #(.ADDR_W(8), .NUM_CH(NCH), .BOARD_ID(BID), .GW_VERSION(GVER)) dut_i (
    .clk, .rst_n, .bus_addr, .bus_wdata, .bus_we, .bus_re, .bus_ack, .bus_rdata,
    .sw_off, .rear_idle, .wdog_expired, .remote_rst, .cnt_load, .cnt_wdata, .cnt_rdata
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    s_ack = bus_ack; s_load = cnt_load; s_rst = remote_rst; s_data = cnt_wdata;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    s_ack = bus_ack; s_data = bus_rdata; s_load = cnt_load; s_rst = remote_rst;
  endtask

  function automatic logic [31:0] stat_exp(input logic tmo);
    return {9'b0, tmo, rear_idle, sw_off, GVER};
  endfunction

  task automatic t_reset();
    chk("R12 ack", {31'b0, bus_ack}, 32'h0);
    chk("R12 rdata", bus_rdata, 32'h0);
    chk("R12 load", {26'b0, cnt_load}, 32'h0);
    chk("R12 rst", {31'b0, remote_rst}, 32'h0);
  endtask

  task automatic t_id();
    rd(8'h00);
    chk("R1 ack", {31'b0, s_ack}, 32'h1);
    chk("R2 id", s_data, BID);
    wr(8'h00, 32'hFFFF_FFFF);
    chk("R1 ack write", {31'b0, s_ack}, 32'h1);
    rd(8'h00);
    chk("R2 id after write", s_data, BID);
    @(negedge clk);
    chk("R1 rdata idle", bus_rdata, 32'h0);
  endtask

  task automatic t_status();
    rd(8'h04);
    chk("R3 status", s_data, stat_exp(1'b0));
    chk("R4 reset flag", {31'b0, s_data[22]}, 32'h0);
    wr(8'h04, 32'hFFBF_FFFF);
    rd(8'h04);
    chk("R3 status write ignored", s_data, stat_exp(1'b0));
  endtask

  task automatic t_timeout();
    @(negedge clk); wdog_expired = 1'b1;
    @(negedge clk); wdog_expired = 1'b0;
    repeat (3) @(negedge clk);
    rd(8'h04);
    chk("R4 flag sticky", s_data, stat_exp(1'b1));
    wr(8'h04, 32'h0000_0000);
    rd(8'h04);
    chk("R5 zero write keeps", {31'b0, s_data[22]}, 32'h1);
    wr(8'h04, 32'h0040_0000);
    rd(8'h04);
    chk("R5 clear", {31'b0, s_data[22]}, 32'h0);
    @(negedge clk);
    bus_addr = 8'h04; bus_wdata = 32'h0040_0000; bus_we = 1'b1; wdog_expired = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; wdog_expired = 1'b0;
    rd(8'h04);
    chk("R5 set wins", {31'b0, s_data[22]}, 32'h1);
    wr(8'h04, 32'h0040_0000);
  endtask

  task automatic t_ctrl();
    rd(8'h08);
    chk("R6 ctrl reset", s_data, 32'h0);
    wr(8'h08, 32'h2);
    chk("R7 no unlock no pulse", {31'b0, s_rst}, 32'h0);
    wr(8'h08, 32'h1);
    chk("R7 unlock alone no pulse", {31'b0, s_rst}, 32'h0);
    rd(8'h08);
    chk("R6 unlock readback", s_data, 32'h1);
    rd(8'h08);
    chk("R8 read keeps unlock", s_data, 32'h1);
    wr(8'h08, 32'h0);
    rd(8'h08);
    chk("R8 zero write clears", s_data, 32'h0);
    wr(8'h08, 32'h2);
    chk("R7 cancelled unlock", {31'b0, s_rst}, 32'h0);
    wr(8'h08, 32'h1);
    wr(8'h08, 32'h2);
    chk("R7 pulse", {31'b0, s_rst}, 32'h1);
    @(negedge clk);
    chk("R7 pulse one cycle", {31'b0, remote_rst}, 32'h0);
    rd(8'h08);
    chk("R8 fire clears unlock", s_data, 32'h0);
    wr(8'h08, 32'h2);
    chk("R7 second needs unlock", {31'b0, s_rst}, 32'h0);
  endtask

  task automatic t_counters();
    for (int k = 0; k < NCH; k++) begin
      rd(8'(8'h0C + 4*k));
      chk("R10 counter read", s_data, 32'hC0DE_0000 + 32'(k * 17));
      wr(8'(8'h0C + 4*k), 32'h1234_0000 + 32'(k));
      chk("R9 load strobe", {26'b0, s_load}, 32'(1 << k));
      chk("R9 load data", s_data, 32'h1234_0000 + 32'(k));
      @(negedge clk);
      chk("R9 strobe one cycle", {26'b0, cnt_load}, 32'h0);
    end
  endtask

  task automatic t_unmapped();
    rd(8'h24);
    chk("R11 ack", {31'b0, s_ack}, 32'h1);
    chk("R11 read zero", s_data, 32'h0);
    rd(8'h0D);
    chk("R11 misaligned zero", s_data, 32'h0);
    wr(8'h08, 32'h1);
    wr(8'h0E, 32'hFFFF_FFFF);
    chk("R11 no load", {26'b0, s_load}, 32'h0);
    chk("R11 no reset", {31'b0, s_rst}, 32'h0);
    wr(8'h40, 32'hFFFF_FFFF);
    chk("R11 no load high", {26'b0, s_load}, 32'h0);
    rd(8'h08);
    chk("R11 ctrl untouched", s_data, 32'h1);
    rd(8'h04);
    chk("R11 status untouched", s_data, stat_exp(1'b0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    sw_off = 8'hA5; rear_idle = 6'b101100; wdog_expired = 1'b0;
    for (int k = 0; k < NCH; k++) cnt_rdata[32*k +: 32] = 32'hC0DE_0000 + 32'(k * 17);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_id();
    t_status();
    t_timeout();
    t_ctrl();
    t_counters();
    t_unmapped();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule